// File: doc/BRIEF.md
# Set/Clear GPIO Register Block

A word-addressed register block that controls `N` general-purpose lines. Line `i` maps to bit `i` of every register, and every register is `N` bits wide. Software reads the line levels through a data register. It changes output levels through a set register and a clear register, where each 1 bit acts on one line, so a write touches no other line. A direction register decides which lines drive their pads.

Build-time parameters decide which of the set, clear and direction registers exist. When the set register is absent, writes to the data register load the output value. When the clear register is absent, a set write loads the output value whole, so 0 bits drive lows. The sense of the direction register can be chosen: a 1 bit either selects output or selects input. An input-only build never enables a pad driver.

Register index on `bus_idx` (byte offset divided by 4): 0 data, 1 set, 2 clear, 3 direction.

Top module: `gpio_setclr`

## Requirements
- R1: While reset is held and just after it, `pad_out` is all zeros. In builds with a direction register, `pad_oe` is all zeros, so every line is an input.
- R2: A read of index 0 returns, in bit `i`, the level that `pad_in[i]` had two rising clock edges earlier. A two-flop synchronizer produces this delay.
- R3: With both set and clear registers present, writing index 1 turns `pad_out` bits with a 1 in the write data high from the next cycle. Bits with a 0 keep their value.
- R4: With a clear register present, writing index 2 turns `pad_out` bits with a 1 in the write data low from the next cycle. Bits with a 0 keep their value.
- R5: With a set register but no clear register, writing index 1 loads `pad_out` with the write data, so 0 bits drive lows.
- R6: With no set register, writing index 0 loads `pad_out` with the write data.
- R7: With the output-select direction sense, a 1 bit written to index 3 sets the matching `pad_oe` bit from the next cycle, and a 0 bit clears it.
- R8: With the input-select direction sense, a 1 bit written to index 3 clears the matching `pad_oe` bit from the next cycle, and a 0 bit sets it.
- R9: Without a direction register, and outside input-only mode, `pad_oe` is all ones after reset.
- R10: In input-only mode, `pad_oe` stays all zeros whatever is written to any index.
- R11: Reads of an absent register return 0. Writes to an absent register leave `pad_out` and `pad_oe` unchanged.
- R12: When present, a read of index 1 or index 2 returns the current output value, and a read of index 3 returns the last value written there (its reset value is all zeros for output-select and all ones for input-select). `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idx | input | 2 | Register index (0 data, 1 set, 2 clear, 3 direction) |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe, gates `bus_rdata` in the same cycle |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data, combinational from index and register state |
| pad_in | input | N | Line levels from the pads |
| pad_out | output | N | Output value per line |
| pad_oe | output | N | Output driver enable per line |

## Verification
The bench runs four instances with `N` = 8 side by side, all on the same bus and pad stimulus. The first has all registers with output-select direction. The second has set but no clear and uses input-select direction. The third has only the data register. The fourth is the full build in input-only mode. Because each instance sees the same writes, every fallback path, both direction senses and the never-drive mode are compared against one behavioural model in the same cycle. The same stimulus also makes writes and reads that reach an absent register in one build land on a present one in another.

// File: rtl/gpio_setclr.sv
module gpio_setclr #(
  parameter int N          = 8,
  parameter int HAS_SET    = 1,
  parameter int HAS_CLR    = 1,
  parameter int HAS_DIR    = 1,
  parameter int DIR_IN_SEL = 0,
  parameter int INPUT_ONLY = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_idx,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [N-1:0] bus_wdata,
  output logic [N-1:0] bus_rdata,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  localparam logic [1:0] IDX_DATA = 2'd0;
  localparam logic [1:0] IDX_SET  = 2'd1;
  localparam logic [1:0] IDX_CLR  = 2'd2;
  localparam logic [1:0] IDX_DIR  = 2'd3;
  localparam logic [N-1:0] DIR_RST = (DIR_IN_SEL != 0) ? '1 : '0;

  logic [N-1:0] meta_q, lvl_q, val_q, dir_q;

  wire wr_data = bus_wr && bus_idx == IDX_DATA && HAS_SET == 0;
  wire wr_set  = bus_wr && bus_idx == IDX_SET  && HAS_SET != 0;
  wire wr_clr  = bus_wr && bus_idx == IDX_CLR  && HAS_CLR != 0;
  wire wr_dir  = bus_wr && bus_idx == IDX_DIR  && HAS_DIR != 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= pad_in;
      lvl_q  <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val_q <= '0;
    else if (wr_data) val_q <= bus_wdata;
    else if (wr_set)  val_q <= (HAS_CLR != 0) ? (val_q | bus_wdata) : bus_wdata;
    else if (wr_clr)  val_q <= val_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= DIR_RST;
    else if (wr_dir) dir_q <= bus_wdata;
  end

  generate
    if (INPUT_ONLY != 0) begin : g_nodrive
      assign pad_oe = '0;
    end else if (HAS_DIR == 0) begin : g_alldrive
      assign pad_oe = '1;
    end else if (DIR_IN_SEL != 0) begin : g_insel
      assign pad_oe = ~dir_q;
    end else begin : g_outsel
      assign pad_oe = dir_q;
    end
  endgenerate

  assign pad_out = val_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_idx)
        IDX_DATA: bus_rdata = lvl_q;
        IDX_SET:  bus_rdata = (HAS_SET != 0) ? val_q : '0;
        IDX_CLR:  bus_rdata = (HAS_CLR != 0) ? val_q : '0;
        IDX_DIR:  bus_rdata = (HAS_DIR != 0) ? dir_q : '0;
      endcase
    end
  end

  // R3
  set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && HAS_CLR != 0) |=>
      ((pad_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));

  // R4
  clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (pad_out & $past(bus_wdata)) == '0);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data || wr_set || wr_clr) |=> $stable(pad_out));

  // R7
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pad_oe));

  // R12
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

// File: tb/gpio_setclr_test.sv
`timescale 1ns/1ps
module gpio_setclr_test;
  localparam int W = 8;
  localparam int HS[4] = '{1, 1, 0, 1};
  localparam int HC[4] = '{1, 0, 0, 1};
  localparam int HD[4] = '{1, 1, 0, 1};
  localparam int IS[4] = '{0, 1, 0, 0};
  localparam int IO[4] = '{0, 0, 0, 1};

  logic clk = 0, rst_n = 0;
  logic [1:0] idx = 0;
  logic wr = 0, rd = 0;
  logic [W-1:0] wdata = 0, pin = 0;
  logic [W-1:0] rdata [4];
  logic [W-1:0] pout [4];
  logic [W-1:0] poe [4];

  int compared = 0, mismatched = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  gpio_setclr #(.N(W), .HAS_SET(HS[0]), .HAS_CLR(HC[0]), .HAS_DIR(HD[0]), .DIR_IN_SEL(IS[0]), .INPUT_ONLY(IO[0])) uut (
    .clk(clk), .rst_n(rst_n), .bus_idx(idx), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata[0]), .pad_in(pin), .pad_out(pout[0]), .pad_oe(poe[0]));
  gpio_setclr #(.N(W), .HAS_SET(HS[1]), .HAS_CLR(HC[1]), .HAS_DIR(HD[1]), .DIR_IN_SEL(IS[1]), .INPUT_ONLY(IO[1])) uut_b (
    .clk(clk), .rst_n(rst_n), .bus_idx(idx), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata[1]), .pad_in(pin), .pad_out(pout[1]), .pad_oe(poe[1]));
  gpio_setclr #(.N(W), .HAS_SET(HS[2]), .HAS_CLR(HC[2]), .HAS_DIR(HD[2]), .DIR_IN_SEL(IS[2]), .INPUT_ONLY(IO[2])) uut_c (
    .clk(clk), .rst_n(rst_n), .bus_idx(idx), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata[2]), .pad_in(pin), .pad_out(pout[2]), .pad_oe(poe[2]));
  gpio_setclr #(.N(W), .HAS_SET(HS[3]), .HAS_CLR(HC[3]), .HAS_DIR(HD[3]), .DIR_IN_SEL(IS[3]), .INPUT_ONLY(IO[3])) uut_d (
    .clk(clk), .rst_n(rst_n), .bus_idx(idx), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata[3]), .pad_in(pin), .pad_out(pout[3]), .pad_oe(poe[3]));

  logic [W-1:0] m_val [4];
  logic [W-1:0] m_dir [4];
  logic [W-1:0] lvl_q [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q = {};
      for (int k = 0; k < 4; k++) begin
        m_val[k] = '0;
        m_dir[k] = (IS[k] != 0) ? '1 : '0;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (wr) begin
          if (idx == 0 && HS[k] == 0) m_val[k] = wdata;
          if (idx == 1 && HS[k] != 0) m_val[k] = (HC[k] != 0) ? (m_val[k] | wdata) : wdata;
          if (idx == 2 && HC[k] != 0) m_val[k] = m_val[k] & ~wdata;
          if (idx == 3 && HD[k] != 0) m_dir[k] = wdata;
        end
      end
      lvl_q.push_back(pin);
      if (lvl_q.size() > 2) void'(lvl_q.pop_front());
    end
  end

  task automatic cmp(int k, string what, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s inst%0d %s: actual=%h expected=%h", tag, k, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #15;
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] e_rd, e_oe;
      e_rd = '0;
      if (rd) begin
        case (idx)
          2'd0: e_rd = (lvl_q.size() == 2) ? lvl_q[0] : '0;
          2'd1: e_rd = (HS[k] != 0) ? m_val[k] : '0;
          2'd2: e_rd = (HC[k] != 0) ? m_val[k] : '0;
          default: e_rd = (HD[k] != 0) ? m_dir[k] : '0;
        endcase
      end
      if (IO[k] != 0) e_oe = '0;
      else if (HD[k] == 0) e_oe = '1;
      else if (IS[k] != 0) e_oe = ~m_dir[k];
      else e_oe = m_dir[k];
      cmp(k, "rdata", rdata[k], e_rd);
      cmp(k, "pad_out", pout[k], m_val[k]);
      cmp(k, "pad_oe", poe[k], e_oe);
    end
  end

  task automatic op(logic [1:0] i, logic w, logic r, logic [W-1:0] d);
    @(negedge clk);
    idx = i; wr = w; rd = r; wdata = d;
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) op(2'd0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    tag = "R2";
    foreach (pin[b]) begin
      @(negedge clk); pin = W'(1) << b; idx = 0; rd = 1;
    end
    op(2'd0, 0, 1, '0); pin = 8'hA5;
    op(2'd0, 0, 1, '0); pin = 8'h5A;
    op(2'd0, 0, 1, '0);
    op(2'd0, 0, 1, '0);
    tag = "R3";
    op(2'd1, 1, 0, 8'h0F);
    op(2'd1, 1, 1, 8'h30);
    op(2'd1, 0, 1, '0);
    tag = "R4";
    op(2'd2, 1, 0, 8'h05);
    op(2'd2, 1, 1, 8'h20);
    op(2'd2, 0, 1, '0);
    tag = "R5";
    op(2'd1, 1, 0, 8'hA5);
    op(2'd1, 1, 0, 8'h00);
    op(2'd1, 0, 1, '0);
    tag = "R6";
    op(2'd0, 1, 0, 8'h3C);
    op(2'd0, 1, 1, 8'hC3);
    op(2'd0, 0, 0, '0);
    tag = "R7";
    op(2'd3, 1, 0, 8'hF0);
    op(2'd3, 0, 1, '0);
    op(2'd3, 1, 0, 8'h81);
    tag = "R8";
    op(2'd3, 1, 0, 8'h0F);
    op(2'd3, 0, 1, '0);
    tag = "R9";
    op(2'd0, 1, 0, 8'hFF);
    idle(2);
    tag = "R10";
    op(2'd3, 1, 0, 8'hFF);
    op(2'd1, 1, 0, 8'hFF);
    idle(2);
    tag = "R11";
    op(2'd2, 1, 1, 8'hFF);
    op(2'd2, 0, 1, '0);
    op(2'd3, 1, 1, 8'h55);
    op(2'd3, 0, 1, '0);
    op(2'd0, 1, 0, 8'h99);
    idle(1);
    tag = "R12";
    for (int i = 0; i < 4; i++) begin
      op(2'(i), 0, 1, '0);
      op(2'(i), 0, 0, '0);
    end
    tag = "R3";
    for (int j = 0; j < 400; j++) begin
      pin = W'($urandom);
      op(2'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
    end
    tag = "R1";
    @(negedge clk); rst_n = 0;
    op(2'd0, 0, 0, '0);
    op(2'd3, 0, 1, '0);
    @(negedge clk); rst_n = 1;
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule